// File: doc/BRIEF.md
# Accumulator ALU with Comparison Flags

An 8-bit arithmetic and logic unit that takes two operands from a register file, selects one of its operations with a 3-bit function code, and keeps the outcome in a dedicated accumulator register. Nothing reaches the accumulator combinationally. A result is captured only on a rising clock edge at which the latch strobe is high. The operands and function code must therefore be stable during the cycle before that edge.

Arithmetic, logic, multiply and single-operand step operations write the accumulator. The compare operation writes a one-hot triple of flags instead: equal, less-than and greater-than. Each kind of operation leaves the other kind's state alone, so a compare can be placed between a computation and its use without disturbing the accumulator.

Eight function codes cover ten operations. The three single-operand operations share one code, and the low two bits of operand B choose among them.

Top module: `acc_alu`

## Requirements
- R1: A clock edge with `rst_n` low clears the accumulator and all three flags to zero.
- R2: A clock edge with `latch_en` low leaves the accumulator and the flags unchanged, whatever the operands and function code.
- R3: Function code 0 stores A+B and code 1 stores A-B, both modulo 256.
- R4: Function code 2 stores the low 8 bits of the unsigned product A*B.
- R5: Function codes 3, 4 and 5 store the bitwise AND, OR and XOR of A and B respectively.
- R6: Function code 6 acts on A alone, with B[1:0] choosing the operation: 00 stores A+1 and 01 stores A-1, both modulo 256; 10 and 11 store A shifted left by one with a zero entering bit 0.
- R7: Function code 7 compares A and B as unsigned numbers. Exactly one flag is set afterwards: `flag_eq` when A equals B, `flag_lt` when A is smaller, and `flag_gt` when A is larger.
- R8: A compare leaves the accumulator unchanged. Every other function code leaves the three flags unchanged.
- R9: A new value appears on `acc` and on the flags only after the clock edge at which it was latched. Changing the inputs between edges does not change the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| opnd_a | input | 8 | First operand |
| opnd_b | input | 8 | Second operand; for code 6, bits 1:0 select the operation |
| fn_code | input | 3 | Function select (see R3 to R7) |
| latch_en | input | 1 | Capture strobe, sampled on the rising clock edge |
| acc | output | 8 | Accumulator value |
| flag_eq | output | 1 | Compare result: A equals B |
| flag_lt | output | 1 | Compare result: A is less than B (unsigned) |
| flag_gt | output | 1 | Compare result: A is greater than B (unsigned) |

## Verification
The assertions assume that `rst_n` is asserted for at least one clock edge before any check matters. They also assume that the function code and strobe are defined values at every edge, so the flag triple starts at zero and can only move to a single set bit. The stimulus holds reset for several edges at start-up and again in mid-run. All inputs change only on the falling clock edge, so each value is stable at the rising edge. Random sequences drop the strobe on about a fifth of the steps and mix compares with computations, which exercises the hold and no-disturb properties while the accumulator holds non-zero state.

// File: rtl/acc_alu_pkg.sv
// Shared function-code encoding for the accumulator ALU.
// Assumes callers cast the raw 3-bit code to alu_fn_e before decoding.
package acc_alu_pkg;
    typedef enum logic [2:0] {
        FN_ADD  = 3'd0,
        FN_SUB  = 3'd1,
        FN_MUL  = 3'd2,
        FN_AND  = 3'd3,
        FN_OR   = 3'd4,
        FN_XOR  = 3'd5,
        FN_STEP = 3'd6,
        FN_CMP  = 3'd7
    } alu_fn_e;

    // Sub-operation select for FN_STEP, carried on operand B bits [1:0].
    localparam logic [1:0] STEP_INC = 2'b00;
    localparam logic [1:0] STEP_DEC = 2'b01;
endpackage

// File: rtl/alu_unary.sv
// Single-operand step unit: increment, decrement or shift left by one.
// Assumes mode bit 1 set means shift, whatever bit 0 holds; results wrap.
module alu_unary
    import acc_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] val,
    input  logic [1:0]       mode,
    output logic [WIDTH-1:0] res
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    // Pick the step operation from the mode bits.
    always_comb begin
        if (mode[1])
            res = {val[WIDTH-2:0], 1'b0};
        else if (mode == STEP_DEC)
            res = val - ONE;
        else
            res = val + ONE;
    end
endmodule

// File: rtl/alu_compare.sv
// Unsigned magnitude comparator producing a one-hot {gt, lt, eq} triple.
// Assumes both operands are unsigned values of equal width.
module alu_compare #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] lhs,
    input  logic [WIDTH-1:0] rhs,
    output logic [2:0]       rel
);
    // Classify the operand pair into exactly one relation.
    always_comb begin
        if (lhs == rhs)
            rel = 3'b001;
        else if (lhs < rhs)
            rel = 3'b010;
        else
            rel = 3'b100;
    end
endmodule

// File: rtl/alu_datapath.sv
// Combinational result path for every function code that writes the
// accumulator. Assumes the compare code's output is ignored by the caller.
module alu_datapath
    import acc_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  alu_fn_e          fn,
    output logic [WIDTH-1:0] result
);
    localparam int PW = 2 * WIDTH;

    logic [PW-1:0]    product;
    logic [WIDTH-1:0] step_res;

    // Full-width product; only the low half is kept.
    assign product = {{WIDTH{1'b0}}, opnd_a} * {{WIDTH{1'b0}}, opnd_b};

    alu_unary #(.WIDTH(WIDTH)) unary_i (
        .val  (opnd_a),
        .mode (opnd_b[1:0]),
        .res  (step_res)
    );

    // Select the result for the current function code.
    always_comb begin
        unique case (fn)
            FN_ADD:  result = opnd_a + opnd_b;
            FN_SUB:  result = opnd_a - opnd_b;
            FN_MUL:  result = product[WIDTH-1:0];
            FN_AND:  result = opnd_a & opnd_b;
            FN_OR:   result = opnd_a | opnd_b;
            FN_XOR:  result = opnd_a ^ opnd_b;
            FN_STEP: result = step_res;
            default: result = '0;
        endcase
    end
endmodule

// File: rtl/acc_alu.sv
// Accumulator ALU top: computes through alu_datapath and alu_compare, and
// captures either the result or the flags on a rising edge with latch_en high.
// Assumes synchronous active-low reset held for at least one edge at start-up.
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [2:0]       fn_code,
    input  logic             latch_en,
    output logic [WIDTH-1:0] acc,
    output logic             flag_eq,
    output logic             flag_lt,
    output logic             flag_gt
);
    alu_fn_e          fn;
    logic [WIDTH-1:0] result;
    logic [2:0]       rel;
    logic [WIDTH-1:0] acc_q;
    logic [2:0]       flags_q;

    assign fn = alu_fn_e'(fn_code);

    alu_datapath #(.WIDTH(WIDTH)) dp_i (
        .opnd_a (opnd_a),
        .opnd_b (opnd_b),
        .fn     (fn),
        .result (result)
    );

    alu_compare #(.WIDTH(WIDTH)) cmp_i (
        .lhs (opnd_a),
        .rhs (opnd_b),
        .rel (rel)
    );

    // Capture either the computed result or the compare flags on the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            flags_q <= '0;
        end else if (latch_en) begin
            if (fn == FN_CMP)
                flags_q <= rel;
            else
                acc_q <= result;
        end
    end

    assign acc     = acc_q;
    assign flag_eq = flags_q[0];
    assign flag_lt = flags_q[1];
    assign flag_gt = flags_q[2];

    // R1: reset clears all architectural state.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (acc == '0 && !flag_eq && !flag_lt && !flag_gt));

    // R2: no strobe, no change.
    a_r2_hold_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_en |=> ($stable(acc) && $stable({flag_gt, flag_lt, flag_eq})));

    // R7: a latched compare leaves exactly one flag set.
    a_r7_cmp_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_en && fn_code == 3'd7) |=> $countones({flag_gt, flag_lt, flag_eq}) == 1);

    // R7: the flag triple is never more than one-hot.
    a_r7_flags_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flag_gt, flag_lt, flag_eq}));

    // R8: compare does not disturb the accumulator.
    a_r8_cmp_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_en && fn_code == 3'd7) |=> $stable(acc));

    // R8: non-compare codes do not disturb the flags.
    a_r8_op_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_en && fn_code != 3'd7) |=> $stable({flag_gt, flag_lt, flag_eq}));

    // R3: a latched add lands its modulo sum in the accumulator.
    a_r3_add_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_en && fn_code == 3'd0) |=> acc == WIDTH'($past(opnd_a) + $past(opnd_b)));
endmodule

// File: tb/acc_alu_tb_top.sv
// Self-checking bench: directed corner cases plus seeded random sequences
// compared against a bench-side reference model.
module acc_alu_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] opnd_a, opnd_b;
    logic [2:0] fn_code;
    logic       latch_en;
    logic [7:0] acc;
    logic       flag_eq, flag_lt, flag_gt;

    int n_tests = 0;
    int n_fail  = 0;

    logic [7:0] m_acc;
    logic [2:0] m_flags; // {gt, lt, eq}

    always #10 clk = ~clk; // 50 MHz

    acc_alu dut_i (
        .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .fn_code(fn_code), .latch_en(latch_en), .acc(acc),
        .flag_eq(flag_eq), .flag_lt(flag_lt), .flag_gt(flag_gt)
    );

    function automatic logic [7:0] ref_result(input logic [7:0] a, input logic [7:0] b,
                                              input logic [2:0] f);
        logic [15:0] p;
        case (f)
            3'd0: return a + b;
            3'd1: return a - b;
            3'd2: begin p = 16'(a) * 16'(b); return p[7:0]; end
            3'd3: return a & b;
            3'd4: return a | b;
            3'd5: return a ^ b;
            3'd6: begin
                if (b[1]) return {a[6:0], 1'b0};
                else if (b[0]) return a - 8'd1;
                else return a + 8'd1;
            end
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [2:0] ref_flags(input logic [7:0] a, input logic [7:0] b);
        if (a == b) return 3'b001;
        if (a < b)  return 3'b010;
        return 3'b100;
    endfunction

    function automatic string tag_of(input logic [2:0] f, input logic le, input logic rs);
        if (!rs) return "R1";
        if (!le) return "R2";
        case (f)
            3'd0, 3'd1: return "R3";
            3'd2: return "R4";
            3'd3, 3'd4, 3'd5: return "R5";
            3'd6: return "R6";
            default: return "R7/R8";
        endcase
    endfunction

    task automatic check(input string tag);
        n_tests++;
        if (acc !== m_acc || {flag_gt, flag_lt, flag_eq} !== m_flags) begin
            n_fail++;
            $display("FAIL %s: acc=%02h flags(gt,lt,eq)=%03b expected acc=%02h flags=%03b",
                     tag, acc, {flag_gt, flag_lt, flag_eq}, m_acc, m_flags);
        end
    endtask

    // Drive at a falling edge, update model for the rising edge, check at the next falling edge.
    task automatic step(input logic rs, input logic [7:0] a, input logic [7:0] b,
                        input logic [2:0] f, input logic le, input string tag);
        @(negedge clk);
        rst_n = rs; opnd_a = a; opnd_b = b; fn_code = f; latch_en = le;
        if (!rs) begin
            m_acc = 8'h00; m_flags = 3'b000;
        end else if (le) begin
            if (f == 3'd7) m_flags = ref_flags(a, b);
            else m_acc = ref_result(a, b, f);
        end
        @(negedge clk);
        check(tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : stim
        logic [31:0] seed_dummy;
        rst_n = 1'b0; opnd_a = 8'h5A; opnd_b = 8'hA5; fn_code = 3'd0; latch_en = 1'b1;
        m_acc = 8'h00; m_flags = 3'b000;
        seed_dummy = $urandom(32'd20240611);

        // R1: reset state, with strobe high and live operands
        step(1'b0, 8'h5A, 8'hA5, 3'd0, 1'b1, "R1");
        step(1'b0, 8'hFF, 8'hFF, 3'd7, 1'b1, "R1");

        // R3: wrap-around add and subtract
        step(1'b1, 8'hFF, 8'h01, 3'd0, 1'b1, "R3");
        step(1'b1, 8'h00, 8'h01, 3'd1, 1'b1, "R3");
        step(1'b1, 8'h80, 8'h80, 3'd0, 1'b1, "R3");
        // R4: product truncation
        step(1'b1, 8'h10, 8'h10, 3'd2, 1'b1, "R4");
        step(1'b1, 8'h0F, 8'h11, 3'd2, 1'b1, "R4");
        step(1'b1, 8'hFF, 8'hFF, 3'd2, 1'b1, "R4");
        // R5: bitwise operations
        step(1'b1, 8'hCC, 8'hAA, 3'd3, 1'b1, "R5");
        step(1'b1, 8'hCC, 8'hAA, 3'd4, 1'b1, "R5");
        step(1'b1, 8'hCC, 8'hAA, 3'd5, 1'b1, "R5");
        // R6: step unit, all selects and wrap points
        step(1'b1, 8'hFF, 8'h00, 3'd6, 1'b1, "R6");
        step(1'b1, 8'h00, 8'h01, 3'd6, 1'b1, "R6");
        step(1'b1, 8'h81, 8'h02, 3'd6, 1'b1, "R6");
        step(1'b1, 8'h7F, 8'hFF, 3'd6, 1'b1, "R6");
        // R7: unsigned compare in all three outcomes; R8: acc untouched
        step(1'b1, 8'h42, 8'h42, 3'd7, 1'b1, "R7");
        step(1'b1, 8'h01, 8'h80, 3'd7, 1'b1, "R7");
        step(1'b1, 8'h80, 8'h01, 3'd7, 1'b1, "R7");
        step(1'b1, 8'h00, 8'hFF, 3'd7, 1'b1, "R8");
        // R8: computation after compare keeps flags
        step(1'b1, 8'h12, 8'h34, 3'd0, 1'b1, "R8");
        // R2: strobe low with every code must not move anything
        for (int f = 0; f < 8; f++)
            step(1'b1, 8'hE7, 8'h3C, 3'(f), 1'b0, "R2");

        // R9: inputs changed between edges without strobe do not reach outputs
        @(negedge clk);
        latch_en = 1'b0; opnd_a = 8'h01; opnd_b = 8'h01; fn_code = 3'd0;
        #5; opnd_a = 8'h77; fn_code = 3'd5;
        #3; check("R9");
        // R9: latched value not visible before the edge
        @(negedge clk);
        latch_en = 1'b1; opnd_a = 8'h20; opnd_b = 8'h03; fn_code = 3'd0;
        #2; check("R9");
        m_acc = 8'h23;
        @(negedge clk); check("R9");

        // Mid-run reset, then random
        step(1'b0, 8'h99, 8'h11, 3'd1, 1'b1, "R1");
        for (int i = 0; i < 600; i++) begin
            logic [7:0] a, b;
            logic [2:0] f;
            logic le, rs;
            a  = 8'($urandom);
            b  = 8'($urandom);
            f  = 3'($urandom);
            le = ($urandom % 5) != 0;
            rs = ($urandom % 97) != 0;
            step(rs, a, b, f, le, tag_of(f, le, rs));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule